// File: doc/BRIEF.md
# BCD Alarm and Periodic Event Detector

This block sits beside a BCD time-of-day and calendar counter. It does not keep time itself. It watches the counter's current seconds, minutes, hours, meridiem flag, weekday, date and month. The counter raises a one-cycle tick strobe in the same cycle that it presents the newly advanced value. On that strobe the detector decides whether a programmed alarm has just been reached. It also decides whether the new value lies on one of the selectable periodic boundaries, for time or for calendar.

Each decision is delivered as a one-cycle pulse in the clock cycle after the tick. An interrupt or flag block downstream can latch these pulses. The alarm compares only the fields whose enable bits are set. The time-event and calendar-event selects each choose one fixed boundary.

Top module: `bcd_event_detect`

## Requirements
- R1: Each tick produces `sec_evt` high for exactly the following clock cycle; `sec_evt` is never high otherwise.
- R2: `alarm_pulse`, `time_evt` and `cal_evt` are high only in the cycle after a tick; field or configuration changes without a tick produce no pulse.
- R3: With `time_sel` = 0, `time_evt` pulses when the ticked value has seconds equal to 8'h00 BCD (minute boundary).
- R4: With `time_sel` = 1, `time_evt` pulses when the ticked value has minutes and seconds both 00 (hour boundary).
- R5: With `time_sel` = 2, `time_evt` pulses at midnight. Midnight is hours 00 with minutes and seconds 00 when `mode12` = 0. It is hours 12 with `cur_pm` = 0 and minutes and seconds 00 when `mode12` = 1.
- R6: With `time_sel` = 3, `time_evt` pulses at noon. Noon is hours 12 with minutes and seconds 00 when `mode12` = 0, and hours 12 with `cur_pm` = 1 when `mode12` = 1.
- R7: With `cal_sel` = 0, `cal_evt` pulses at midnight (as in R5) when `cur_dow` = 1 (Monday).
- R8: With `cal_sel` = 1, `cal_evt` pulses at midnight when the date is 01. With `cal_sel` = 2, it pulses at midnight when the date is 01 and the month is 01. `cal_sel` = 3 never produces a pulse.
- R9: Alarm enable bits are `alm_en`[0] seconds, [1] minutes, [2] hours, [3] date, [4] month. Only enabled fields are compared. `alm_pm` is compared with `cur_pm` as part of the hours field, and only when `mode12` = 1.
- R10: `alarm_pulse` fires only on a tick where the enabled fields match and did not match at the previous tick. A repeated matching tick gives no second pulse. With `alm_en` = 0 no alarm is ever produced.
- R11: During and right after reset all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, time value just advanced |
| mode12 | input | 1 | 1 = 12-hour mode with meridiem flag |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_pm | input | 1 | Current meridiem, 1 = PM |
| cur_dow | input | 3 | Current weekday, 1 = Monday |
| cur_date | input | 6 | Current day of month, BCD |
| cur_month | input | 5 | Current month, BCD |
| alm_sec | input | 7 | Alarm seconds, BCD |
| alm_min | input | 7 | Alarm minutes, BCD |
| alm_hour | input | 6 | Alarm hours, BCD |
| alm_pm | input | 1 | Alarm meridiem |
| alm_date | input | 6 | Alarm date, BCD |
| alm_month | input | 5 | Alarm month, BCD |
| alm_en | input | 5 | Per-field alarm enables |
| time_sel | input | 2 | Periodic time boundary select |
| cal_sel | input | 2 | Periodic calendar boundary select |
| alarm_pulse | output | 1 | Alarm reached |
| time_evt | output | 1 | Time boundary reached |
| cal_evt | output | 1 | Calendar boundary reached |
| sec_evt | output | 1 | Second elapsed |

## Verification
The hardest case to reach is the once-only alarm behaviour. It depends on the match state left by the previous tick, so a single vector cannot show it. The stimulus table is ordered to build that state on purpose. A non-matching tick comes first, then a matching one, then the same matching value ticked again. Further entries change the enables and the meridiem so that the remembered match flips in both directions before the next alarm is expected. The 12-hour midnight and noon entries mirror one another, so a swapped meridiem decode is caught.

// File: rtl/bcd_evt_pkg.sv
package bcd_evt_pkg;
    localparam int SEC_W   = 7;
    localparam int MIN_W   = 7;
    localparam int HOUR_W  = 6;
    localparam int DOW_W   = 3;
    localparam int DATE_W  = 6;
    localparam int MONTH_W = 5;
    localparam int EN_W    = 5;

    typedef enum logic [1:0] {
        TEV_MINUTE   = 2'd0,
        TEV_HOUR     = 2'd1,
        TEV_MIDNIGHT = 2'd2,
        TEV_NOON     = 2'd3
    } tev_sel_e;

    typedef enum logic [1:0] {
        CEV_WEEK  = 2'd0,
        CEV_MONTH = 2'd1,
        CEV_YEAR  = 2'd2,
        CEV_NONE  = 2'd3
    } cev_sel_e;

    typedef struct packed {
        logic alarm;
        logic tev;
        logic cev;
        logic sec;
        logic matched;
    } evt_state_t;
endpackage

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
    import bcd_evt_pkg::*;
(
    input  logic               mode12,
    input  logic [SEC_W-1:0]   cur_sec,
    input  logic [MIN_W-1:0]   cur_min,
    input  logic [HOUR_W-1:0]  cur_hour,
    input  logic               cur_pm,
    input  logic [DATE_W-1:0]  cur_date,
    input  logic [MONTH_W-1:0] cur_month,
    input  logic [SEC_W-1:0]   alm_sec,
    input  logic [MIN_W-1:0]   alm_min,
    input  logic [HOUR_W-1:0]  alm_hour,
    input  logic               alm_pm,
    input  logic [DATE_W-1:0]  alm_date,
    input  logic [MONTH_W-1:0] alm_month,
    input  logic [EN_W-1:0]    alm_en,
    output logic               match
);
    logic [EN_W-1:0] field_eq;
    logic [EN_W-1:0] field_ok;

    always_comb begin
        field_eq[0] = (cur_sec == alm_sec);
        field_eq[1] = (cur_min == alm_min);
        field_eq[2] = (cur_hour == alm_hour) && (!mode12 || (cur_pm == alm_pm));
        field_eq[3] = (cur_date == alm_date);
        field_eq[4] = (cur_month == alm_month);
    end

    // a disabled field never blocks the match
    for (genvar g = 0; g < EN_W; g++) begin : g_field
        assign field_ok[g] = field_eq[g] || !alm_en[g];
    end

    assign match = (|alm_en) && (&field_ok);
endmodule

// File: rtl/bcd_boundary_decode.sv
module bcd_boundary_decode
    import bcd_evt_pkg::*;
(
    input  logic               mode12,
    input  logic [SEC_W-1:0]   cur_sec,
    input  logic [MIN_W-1:0]   cur_min,
    input  logic [HOUR_W-1:0]  cur_hour,
    input  logic               cur_pm,
    input  logic [DOW_W-1:0]   cur_dow,
    input  logic [DATE_W-1:0]  cur_date,
    input  logic [MONTH_W-1:0] cur_month,
    input  logic [1:0]         time_sel,
    input  logic [1:0]         cal_sel,
    output logic               time_hit,
    output logic               cal_hit
);
    localparam logic [HOUR_W-1:0] HOUR_ZERO   = HOUR_W'(6'h00);
    localparam logic [HOUR_W-1:0] HOUR_TWELVE = HOUR_W'(6'h12);

    logic top_of_min, top_of_hour, at_midnight, at_noon;

    always_comb begin
        top_of_min  = (cur_sec == '0);
        top_of_hour = top_of_min && (cur_min == '0);
        if (mode12) begin
            at_midnight = top_of_hour && (cur_hour == HOUR_TWELVE) && !cur_pm;
            at_noon     = top_of_hour && (cur_hour == HOUR_TWELVE) &&  cur_pm;
        end else begin
            at_midnight = top_of_hour && (cur_hour == HOUR_ZERO);
            at_noon     = top_of_hour && (cur_hour == HOUR_TWELVE);
        end

        unique case (tev_sel_e'(time_sel))
            TEV_MINUTE:   time_hit = top_of_min;
            TEV_HOUR:     time_hit = top_of_hour;
            TEV_MIDNIGHT: time_hit = at_midnight;
            default:      time_hit = at_noon;
        endcase

        unique case (cev_sel_e'(cal_sel))
            CEV_WEEK:  cal_hit = at_midnight && (cur_dow == DOW_W'(1));
            CEV_MONTH: cal_hit = at_midnight && (cur_date == DATE_W'(1));
            CEV_YEAR:  cal_hit = at_midnight && (cur_date == DATE_W'(1))
                                 && (cur_month == MONTH_W'(1));
            default:   cal_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcd_event_detect.sv
module bcd_event_detect
    import bcd_evt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               mode12,
    input  logic [SEC_W-1:0]   cur_sec,
    input  logic [MIN_W-1:0]   cur_min,
    input  logic [HOUR_W-1:0]  cur_hour,
    input  logic               cur_pm,
    input  logic [DOW_W-1:0]   cur_dow,
    input  logic [DATE_W-1:0]  cur_date,
    input  logic [MONTH_W-1:0] cur_month,
    input  logic [SEC_W-1:0]   alm_sec,
    input  logic [MIN_W-1:0]   alm_min,
    input  logic [HOUR_W-1:0]  alm_hour,
    input  logic               alm_pm,
    input  logic [DATE_W-1:0]  alm_date,
    input  logic [MONTH_W-1:0] alm_month,
    input  logic [EN_W-1:0]    alm_en,
    input  logic [1:0]         time_sel,
    input  logic [1:0]         cal_sel,
    output logic               alarm_pulse,
    output logic               time_evt,
    output logic               cal_evt,
    output logic               sec_evt
);
    logic       match, time_hit, cal_hit;
    evt_state_t st_d, st_q;

    bcd_alarm_match u_match (
        .mode12(mode12), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_pm(cur_pm), .cur_date(cur_date), .cur_month(cur_month),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour), .alm_pm(alm_pm),
        .alm_date(alm_date), .alm_month(alm_month), .alm_en(alm_en), .match(match)
    );

    bcd_boundary_decode u_bound (
        .mode12(mode12), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_pm(cur_pm), .cur_dow(cur_dow), .cur_date(cur_date), .cur_month(cur_month),
        .time_sel(time_sel), .cal_sel(cal_sel), .time_hit(time_hit), .cal_hit(cal_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.alarm = 1'b0;
        st_d.tev   = 1'b0;
        st_d.cev   = 1'b0;
        st_d.sec   = 1'b0;
        if (tick) begin
            st_d.sec     = 1'b1;
            st_d.tev     = time_hit;
            st_d.cev     = cal_hit;
            st_d.alarm   = match && !st_q.matched;
            st_d.matched = match;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alarm_pulse = st_q.alarm;
    assign time_evt    = st_q.tev;
    assign cal_evt     = st_q.cev;
    assign sec_evt     = st_q.sec;

    // R1
    sec_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> sec_evt);
    // R1
    sec_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_evt |-> $past(tick));
    // R2
    evt_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_pulse || time_evt || cal_evt) |-> $past(tick));
    // R8
    cal_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_evt |-> ($past(cal_sel) != 2'd3));
    // R10
    alarm_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse |-> ($past(alm_en) != '0));
    // R10
    alarm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse |=> !alarm_pulse);
endmodule

// File: tb/bcd_event_detect_test.sv
module bcd_event_detect_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic mode12 = 1'b0;
    logic [6:0] cur_sec = '0, cur_min = '0;
    logic [5:0] cur_hour = '0;
    logic       cur_pm = 1'b0;
    logic [2:0] cur_dow = 3'd3;
    logic [5:0] cur_date = 6'h05;
    logic [4:0] cur_month = 5'h02;
    logic [6:0] alm_sec = 7'h30, alm_min = 7'h45;
    logic [5:0] alm_hour = 6'h07;
    logic       alm_pm = 1'b1;
    logic [5:0] alm_date = 6'h15;
    logic [4:0] alm_month = 5'h06;
    logic [4:0] alm_en = '0;
    logic [1:0] time_sel = '0, cal_sel = 2'd3;
    logic alarm_pulse, time_evt, cal_evt, sec_evt;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    bcd_event_detect uut (.*);

    typedef struct packed {
        bit       m12; bit pm; bit [5:0] h; bit [6:0] mi; bit [6:0] s;
        bit [2:0] dow; bit [5:0] dt; bit [4:0] mo;
        bit [1:0] ts; bit [1:0] cs; bit [4:0] en;
        bit       ea; bit et; bit ec;
    } vec_t;

    // m12 pm h mi s dow dt mo ts cs en | alarm tev cev
    localparam vec_t TBL [26] = '{
        '{0,0,6'h10,7'h20,7'h05,3'd3,6'h05,5'h02,2'd0,2'd3,5'h00, 0,0,0}, // R3 no boundary
        '{0,0,6'h10,7'h21,7'h00,3'd3,6'h05,5'h02,2'd0,2'd3,5'h00, 0,1,0}, // R3 minute
        '{0,0,6'h10,7'h21,7'h00,3'd3,6'h05,5'h02,2'd1,2'd3,5'h00, 0,0,0}, // R4 not hour
        '{0,0,6'h11,7'h00,7'h00,3'd3,6'h05,5'h02,2'd1,2'd3,5'h00, 0,1,0}, // R4 hour
        '{0,0,6'h00,7'h00,7'h00,3'd1,6'h05,5'h02,2'd2,2'd0,5'h00, 0,1,1}, // R5 R7 Monday midnight
        '{0,0,6'h00,7'h00,7'h00,3'd2,6'h05,5'h02,2'd3,2'd0,5'h00, 0,0,0}, // R6 R7 Tuesday
        '{0,0,6'h12,7'h00,7'h00,3'd2,6'h01,5'h02,2'd3,2'd1,5'h00, 0,1,0}, // R6 noon, R8 not midnight
        '{0,0,6'h00,7'h00,7'h00,3'd2,6'h01,5'h02,2'd0,2'd1,5'h00, 0,1,1}, // R8 month
        '{0,0,6'h00,7'h00,7'h00,3'd2,6'h01,5'h02,2'd1,2'd2,5'h00, 0,1,0}, // R8 year, Feb
        '{0,0,6'h00,7'h00,7'h00,3'd2,6'h01,5'h01,2'd2,2'd2,5'h00, 0,1,1}, // R8 year, Jan 1
        '{0,0,6'h00,7'h00,7'h00,3'd1,6'h01,5'h01,2'd2,2'd3,5'h00, 0,1,0}, // R8 reserved
        '{1,0,6'h12,7'h00,7'h00,3'd1,6'h01,5'h01,2'd2,2'd0,5'h00, 0,1,1}, // R5 12h midnight
        '{1,1,6'h12,7'h00,7'h00,3'd1,6'h01,5'h01,2'd2,2'd0,5'h00, 0,0,0}, // R5 12h PM not midnight
        '{1,1,6'h12,7'h00,7'h00,3'd1,6'h05,5'h02,2'd3,2'd3,5'h00, 0,1,0}, // R6 12h noon
        '{1,0,6'h12,7'h00,7'h00,3'd1,6'h05,5'h02,2'd3,2'd3,5'h00, 0,0,0}, // R6 12h AM not noon
        '{0,0,6'h00,7'h00,7'h00,3'd1,6'h05,5'h02,2'd3,2'd3,5'h00, 0,0,0}, // R6 24h midnight not noon
        '{0,0,6'h08,7'h15,7'h29,3'd3,6'h05,5'h02,2'd0,2'd3,5'h01, 0,0,0}, // R9 sec mismatch
        '{0,0,6'h08,7'h15,7'h30,3'd3,6'h05,5'h02,2'd0,2'd3,5'h01, 1,0,0}, // R9 sec match
        '{0,0,6'h08,7'h15,7'h30,3'd3,6'h05,5'h02,2'd0,2'd3,5'h01, 0,0,0}, // R10 repeat
        '{0,0,6'h08,7'h15,7'h31,3'd3,6'h05,5'h02,2'd0,2'd3,5'h01, 0,0,0}, // R10 leave
        '{0,0,6'h08,7'h45,7'h30,3'd3,6'h05,5'h02,2'd0,2'd3,5'h03, 1,0,0}, // R9 sec+min
        '{1,0,6'h07,7'h45,7'h30,3'd3,6'h05,5'h02,2'd0,2'd3,5'h07, 0,0,0}, // R9 pm mismatch
        '{1,1,6'h07,7'h45,7'h30,3'd3,6'h05,5'h02,2'd0,2'd3,5'h07, 1,0,0}, // R9 pm match
        '{0,0,6'h01,7'h02,7'h03,3'd3,6'h14,5'h06,2'd0,2'd3,5'h18, 0,0,0}, // R9 date mismatch
        '{0,0,6'h01,7'h02,7'h03,3'd3,6'h15,5'h06,2'd0,2'd3,5'h18, 1,0,0}, // R9 date+month
        '{0,0,6'h07,7'h45,7'h30,3'd3,6'h15,5'h06,2'd0,2'd3,5'h00, 0,0,0}  // R10 no enables
    };

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        mode12 = v.m12; cur_pm = v.pm; cur_hour = v.h; cur_min = v.mi; cur_sec = v.s;
        cur_dow = v.dow; cur_date = v.dt; cur_month = v.mo;
        time_sel = v.ts; cal_sel = v.cs; alm_en = v.en;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        #500000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 outputs low in reset
        chk("R11 alarm", alarm_pulse, 1'b0);
        chk("R11 tev", time_evt, 1'b0);
        chk("R11 cev", cal_evt, 1'b0);
        chk("R11 sec", sec_evt, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 sec after", sec_evt, 1'b0);

        for (int i = 0; i < 26; i++) begin
            apply(TBL[i]);
            do_tick();
            chk("R1 sec_evt", sec_evt, 1'b1);
            chk("R9/R10 alarm", alarm_pulse, TBL[i].ea);
            chk("R3-6 time_evt", time_evt, TBL[i].et);
            chk("R7/R8 cal_evt", cal_evt, TBL[i].ec);
            @(negedge clk);
            chk("R1 sec_evt single", sec_evt, 1'b0);
        end

        // R2 boundary value and matching alarm with no tick
        apply('{0,0,6'h00,7'h00,7'h00,3'd1,6'h01,5'h01,2'd2,2'd2,5'h01, 0,0,0});
        alm_sec = 7'h00;
        repeat (3) begin
            @(negedge clk);
            chk("R2 tev no tick", time_evt, 1'b0);
            chk("R2 cev no tick", cal_evt, 1'b0);
            chk("R2 alarm no tick", alarm_pulse, 1'b0);
            chk("R1 sec no tick", sec_evt, 1'b0);
        end
        // R10 remembered mismatch from last table tick: the first tick fires
        do_tick();
        chk("R10 alarm after idle", alarm_pulse, 1'b1);
        chk("R5 tev on tick", time_evt, 1'b1);
        chk("R8 cev on tick", cal_evt, 1'b1);

        // R11 reset mid-run clears outputs
        tick = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        chk("R11 sec in reset", sec_evt, 1'b0);
        chk("R11 alarm in reset", alarm_pulse, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule